// File: doc/BRIEF.md
# Masked Interrupt Status Register Group

This block is a small group of memory-mapped registers that drives one level-sensitive interrupt line. A hardware event input sets a pending bit. Software clears that bit by writing a one to it. A mask decides whether a pending bit reaches the interrupt line. Software cannot write the mask directly. It can only clear mask bits through an unmask alias or set them through a mask alias, and both aliases read back as zero. The interrupt output is a flop. It is loaded from the next-state values of status and mask, so it follows any change to either on the same clock edge that stores the change.

The register bus carries 32-bit data. Each access has a select, a write strobe, an address, write data and four byte-lane enables. Only full-word accesses are legal. Data is little-endian, so bit 0 of a register lies in byte lane 0. A narrower access raises a one-cycle error pulse and changes nothing. Read data is registered and appears one cycle after the access. The number of event sources is a parameter (`N_SRC`), with the default set to a single source.

Top module: `irq_stat_regs`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `irq` is 0, `bus_err` is 0 and `bus_rdata` is 0. After reset, the status register reads 0 and the mask register reads all ones in its low `N_SRC` bits, so every source starts masked.
- R2: `irq` is 1 exactly when some status bit is 1 and its matching mask bit is 0. `irq` reflects an access or event in the cycle that follows it.
- R3: A legal write to the status register (offset 0x0) clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R4: A 1 on `evt[i]` sets status bit i. If a clear of that bit arrives in the same cycle, the event wins and the bit stays 1.
- R5: The mask register (offset 0x4) can be read. Writes to it have no effect.
- R6: A legal write to the unmask alias (offset 0x8) clears each mask bit whose write-data bit is 1. All other mask bits are left unchanged.
- R7: A legal write to the mask alias (offset 0xC) sets each mask bit whose write-data bit is 1. All other mask bits are left unchanged.
- R8: The unmask and mask aliases hold no state and read as 0.
- R9: An access is legal only when all four byte enables are 1 (`bus_be == 4'hF`). Any other selected access makes `bus_err` 1 in the next cycle. Such an access is otherwise ignored: no register changes and the read data is 0.
- R10: A legal read returns the addressed register in `bus_rdata` one cycle later, with bits at and above `N_SRC` reading as 0. Unmapped addresses read as 0 and ignore writes. `bus_rdata` is 0 in any cycle that follows no legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte-lane enables, lane 0 = bits 7:0 |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Illegal-size access seen in the previous cycle |
| evt | input | N_SRC | Hardware event pulses, one per status bit |
| irq | output | 1 | Level interrupt, registered |

## Verification
The assertions assume that at most one bus access occurs per cycle and that every input is free of X after reset. The mask-alias checks also assume that no other register changes the mask in the same cycle, which holds because only one address is decoded at a time. The bench drives one access per cycle at the falling clock edge. It draws addresses from the four mapped offsets plus an unmapped value, and it sends a mix of byte-enable patterns and event pulses, so every stimulus stays inside those assumptions. It also covers, with directed cases, the collision between an event and a clear and the case of a write to the read-only mask.

// File: rtl/irq_regs_pkg.sv
// Shared constants and types for the masked interrupt register group.
// Assumes a 32-bit register bus with byte addressing and word-aligned offsets.
package irq_regs_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned BE_W  = BUS_W / 8;

    localparam logic [3:0] OFS_STATUS  = 4'h0;
    localparam logic [3:0] OFS_MASK    = 4'h4;
    localparam logic [3:0] OFS_UNMASK  = 4'h8;
    localparam logic [3:0] OFS_MASKSET = 4'hC;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_MASK    = 2'd1,
        SEL_UNMASK  = 2'd2,
        SEL_MASKSET = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e which;
        logic     wr_ok;
        logic     rd_ok;
        logic     bad_size;
    } bus_dec_t;
endpackage

// File: rtl/irq_bus_decode.sv
// Decodes one register-bus access into a target register and legal/illegal flags.
// Assumes at most one access per cycle; purely combinational.
module irq_bus_decode
    import irq_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_dec_t          dec
);
    localparam logic [BE_W-1:0] FULL_WORD = {BE_W{1'b1}};

    logic full;

    // Size check and address match for the four mapped offsets.
    always_comb begin
        full          = (bus_be == FULL_WORD);
        dec           = '0;
        dec.wr_ok     = bus_sel && bus_wr && full;
        dec.rd_ok     = bus_sel && !bus_wr && full;
        dec.bad_size  = bus_sel && !full;
        dec.hit       = 1'b1;
        dec.which     = SEL_STATUS;
        if (bus_addr == ADDR_W'(OFS_STATUS))       dec.which = SEL_STATUS;
        else if (bus_addr == ADDR_W'(OFS_MASK))    dec.which = SEL_MASK;
        else if (bus_addr == ADDR_W'(OFS_UNMASK))  dec.which = SEL_UNMASK;
        else if (bus_addr == ADDR_W'(OFS_MASKSET)) dec.which = SEL_MASKSET;
        else                                       dec.hit   = 1'b0;
    end
endmodule

// File: rtl/irq_status_bank.sv
// Holds the pending-status and mask bits, one slice per event source.
// Assumes write strobes are mutually exclusive; events take priority over clears.
module irq_status_bank #(
    parameter int unsigned N_SRC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             clr_we,
    input  logic             unmask_we,
    input  logic             maskset_we,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] stat_q,
    output logic [N_SRC-1:0] mask_q,
    output logic [N_SRC-1:0] stat_d,
    output logic [N_SRC-1:0] mask_d
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_slice
        // Next status: write-one-to-clear, then event set wins.
        always_comb begin
            stat_d[i] = stat_q[i];
            if (clr_we && wbits[i]) stat_d[i] = 1'b0;
            if (evt[i])             stat_d[i] = 1'b1;
        end

        // Next mask: only the alias strobes may move it.
        always_comb begin
            mask_d[i] = mask_q[i];
            if (unmask_we && wbits[i])  mask_d[i] = 1'b0;
            if (maskset_we && wbits[i]) mask_d[i] = 1'b1;
        end

        // Storage with synchronous reset: clear status, mask set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[i] <= 1'b0;
                mask_q[i] <= 1'b1;
            end else begin
                stat_q[i] <= stat_d[i];
                mask_q[i] <= mask_d[i];
            end
        end
    end
endmodule

// File: rtl/irq_out_stage.sv
// Registers read data, the size-error pulse and the interrupt line.
// Assumes stat_d/mask_d are the values the bank stores on this edge.
module irq_out_stage
    import irq_regs_pkg::*;
#(
    parameter int unsigned N_SRC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_dec_t         dec,
    input  logic [N_SRC-1:0] stat_q,
    input  logic [N_SRC-1:0] mask_q,
    input  logic [N_SRC-1:0] stat_d,
    input  logic [N_SRC-1:0] mask_d,
    output logic [BUS_W-1:0] rdata_q,
    output logic             err_q,
    output logic             irq_q
);
    logic [BUS_W-1:0] rd_mux;

    // Read multiplexer; aliases and unmapped offsets return zero.
    always_comb begin
        rd_mux = '0;
        if (dec.rd_ok && dec.hit) begin
            case (dec.which)
                SEL_STATUS: rd_mux = BUS_W'(stat_q);
                SEL_MASK:   rd_mux = BUS_W'(mask_q);
                default:    rd_mux = '0;
            endcase
        end
    end

    // Output flops: read data, error pulse, interrupt from next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            rdata_q <= rd_mux;
            err_q   <= dec.bad_size;
            irq_q   <= |(stat_d & ~mask_d);
        end
    end
endmodule

// File: rtl/irq_stat_regs.sv
// Top of the masked interrupt register group: decode, status/mask bank, outputs.
// Assumes word-sized little-endian accesses; narrower ones are flagged and dropped.
module irq_stat_regs
    import irq_regs_pkg::*;
#(
    parameter int unsigned N_SRC  = 1,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [N_SRC-1:0]  evt,
    output logic              irq
);
    bus_dec_t         dec;
    logic [N_SRC-1:0] stat_q, mask_q, stat_d, mask_d;
    logic             wr_hit;

    irq_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_be   (bus_be),
        .bus_addr (bus_addr),
        .dec      (dec)
    );

    // Legal write that lands on a mapped offset.
    always_comb wr_hit = dec.wr_ok && dec.hit;

    irq_status_bank #(.N_SRC(N_SRC)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .clr_we     (wr_hit && dec.which == SEL_STATUS),
        .unmask_we  (wr_hit && dec.which == SEL_UNMASK),
        .maskset_we (wr_hit && dec.which == SEL_MASKSET),
        .wbits      (bus_wdata[N_SRC-1:0]),
        .stat_q     (stat_q),
        .mask_q     (mask_q),
        .stat_d     (stat_d),
        .mask_d     (mask_d)
    );

    irq_out_stage #(.N_SRC(N_SRC)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .stat_d  (stat_d),
        .mask_d  (mask_d),
        .rdata_q (bus_rdata),
        .err_q   (bus_err),
        .irq_q   (irq)
    );
endmodule

// File: rtl/irq_stat_regs_chk.sv
// Property checker for irq_stat_regs, attached by bind below.
// Assumes one access per cycle and X-free inputs after reset.
module irq_stat_regs_chk #(
    parameter int unsigned N_SRC  = 1,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [3:0]        bus_be,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_err,
    input logic [N_SRC-1:0]  evt,
    input logic              irq,
    input logic [N_SRC-1:0]  stat,
    input logic [N_SRC-1:0]  mask
);
    logic good_wr;
    always_comb good_wr = bus_sel && bus_wr && (bus_be == 4'hF);

    // R2
    irq_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat & ~mask));

    // R4
    event_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat & $past(evt)) == $past(evt)));

    // R6
    unmask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && bus_addr == ADDR_W'(8)) |=> ((mask & $past(bus_wdata[N_SRC-1:0])) == '0));

    // R7
    maskset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && bus_addr == ADDR_W'(12)) |=>
        ((mask & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    // R5
    mask_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && bus_addr == ADDR_W'(4)) |=> $stable(mask));

    // R9
    bad_size_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_be != 4'hF) |=> (bus_err && $stable(mask)));
endmodule

bind irq_stat_regs irq_stat_regs_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .evt       (evt),
    .irq       (irq),
    .stat      (stat_q),
    .mask      (mask_q)
);

// File: tb/irq_stat_regs_tb_top.sv
`timescale 1ns/1ps
module irq_stat_regs_tb_top;
    localparam int unsigned NS = 2;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]    bus_be = 4'h0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err, irq;
    logic [NS-1:0] evt = '0;

    int checks = 0;
    int failures = 0;

    logic [NS-1:0] m_stat, m_mask;
    logic [31:0]   m_rdata;
    logic          m_err, m_irq;

    always #2.5 clk = ~clk;

    irq_stat_regs #(.N_SRC(NS), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .evt(evt), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model of one clock edge, written from the requirements.
    function automatic void model_step(logic s, logic w, logic [3:0] be,
                                       logic [AW-1:0] a, logic [31:0] wd, logic [NS-1:0] e);
        logic good = s && (be == 4'hF);
        logic [NS-1:0] wb = wd[NS-1:0];
        m_err   = s && !good;
        m_rdata = '0;
        if (good && !w) begin
            if (a == AW'(0)) m_rdata = 32'(m_stat);
            if (a == AW'(4)) m_rdata = 32'(m_mask);
        end
        if (good && w && a == AW'(0))  m_stat = m_stat & ~wb;
        m_stat = m_stat | e;
        if (good && w && a == AW'(8))  m_mask = m_mask & ~wb;
        if (good && w && a == AW'(12)) m_mask = m_mask | wb;
        m_irq = |(m_stat & ~m_mask);
    endfunction

    // Drive one access at the falling edge, check after the next rising edge.
    task automatic step(string tag, logic s, logic w, logic [3:0] be,
                        logic [AW-1:0] a, logic [31:0] wd, logic [NS-1:0] e);
        bus_sel = s; bus_wr = w; bus_be = be; bus_addr = a; bus_wdata = wd; evt = e;
        model_step(s, w, be, a, wd, e);
        @(negedge clk);
        check({tag, " irq"},   32'(irq),     32'(m_irq));
        check({tag, " err"},   32'(bus_err), 32'(m_err));
        check({tag, " rdata"}, bus_rdata,    m_rdata);
        bus_sel = 1'b0; evt = '0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        m_stat = '0; m_mask = '1;
        repeat (4) @(negedge clk);
        // R1: outputs held low in reset
        check("R1 irq in reset", 32'(irq), 0);
        check("R1 err in reset", 32'(bus_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 rdata after reset", bus_rdata, 0);
        step("R1 status reset", 1, 0, 4'hF, AW'(0), 0, '0);
        check("R1 status reads 0", bus_rdata, 0);
        step("R1 mask reset", 1, 0, 4'hF, AW'(4), 0, '0);
        check("R1 mask reads ones", bus_rdata, 32'h3);
        // R2: event while masked keeps irq low
        step("R2 masked event", 0, 0, 4'h0, '0, 0, 2'b01);
        check("R2 masked irq low", 32'(irq), 0);
        // R6: unmask bit 0 -> irq rises next cycle
        step("R6 unmask", 1, 1, 4'hF, AW'(8), 32'h1, '0);
        check("R6 irq raised", 32'(irq), 1);
        // R3: writing zero leaves status
        step("R3 write zero", 1, 1, 4'hF, AW'(0), 32'h0, '0);
        check("R3 irq kept", 32'(irq), 1);
        // R4: clear and event together, event wins
        step("R4 collision", 1, 1, 4'hF, AW'(0), 32'h1, 2'b01);
        check("R4 irq kept", 32'(irq), 1);
        // R3: write one clears
        step("R3 clear", 1, 1, 4'hF, AW'(0), 32'h1, '0);
        check("R3 irq dropped", 32'(irq), 0);
        // R5: write to mask register ignored
        step("R5 mask write", 1, 1, 4'hF, AW'(4), 32'h0, '0);
        step("R5 mask read", 1, 0, 4'hF, AW'(4), 0, '0);
        check("R5 mask unchanged", bus_rdata, 32'h2);
        // R8: aliases read zero
        step("R8 unmask read", 1, 0, 4'hF, AW'(8), 0, '0);
        check("R8 unmask reads 0", bus_rdata, 0);
        step("R8 maskset read", 1, 0, 4'hF, AW'(12), 0, '0);
        check("R8 maskset reads 0", bus_rdata, 0);
        // R7: re-mask while pending
        step("R7 pend", 0, 0, 4'h0, '0, 0, 2'b01);
        step("R7 maskset", 1, 1, 4'hF, AW'(12), 32'h1, '0);
        check("R7 irq masked", 32'(irq), 0);
        // R9: narrow write to unmask is dropped and flagged
        step("R9 narrow write", 1, 1, 4'h1, AW'(8), 32'h3, '0);
        check("R9 err pulse", 32'(bus_err), 1);
        check("R9 irq still masked", 32'(irq), 0);
        step("R9 narrow read", 1, 0, 4'h3, AW'(0), 0, '0);
        check("R9 narrow read zero", bus_rdata, 0);
        // R10: unmapped read is zero
        step("R10 unmapped", 1, 0, 4'hF, AW'(6), 0, '0);
        check("R10 unmapped zero", bus_rdata, 0);
        // Random mix, every cycle compared against the model (R2 R3 R4 R6 R7 R9 R10)
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]    be;
            logic [AW-1:0] a;
            int            pick = $urandom_range(0, 4);
            a  = (pick == 4) ? AW'($urandom_range(0, 15)) : AW'(pick * 4);
            be = ($urandom_range(0, 3) != 0) ? 4'hF : 4'($urandom_range(0, 15));
            step("R2 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), be, a,
                 $urandom(), ($urandom_range(0, 3) == 0) ? NS'($urandom()) : '0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule